// File: doc/BRIEF.md
# Programmable Half-Duty Clock Divider

This block takes a free-running input clock and produces a slower clock whose frequency is the input frequency divided by a run-time integer ratio. The output stays high for exactly half of every output period, and this holds for odd ratios as well as even ones. A single counter running on the input's rising edge cannot produce a half-cycle step. For odd ratios, a second counter clocked on the falling edge supplies a phase signal that trails or leads the first by half an input period. The two phase signals are then ORed, which stretches the high time by that half period.

For even ratios only the rising-edge counter runs. Its phase flop drives the output directly, and the falling-edge path is held cleared. A ratio of 0 or 1 is not a valid division and parks the output low. The ratio is meant to be set while the divider is held in reset. A change made while it runs is not guaranteed to be free of glitches. The 50% figure for odd ratios assumes the input clock itself has a 50% duty cycle.

Top module: `clkdiv_half_duty`

## Requirements
- R1: With a ratio N of at least 2, the output period is N input clock periods (2N half input periods). Each internal counter steps through 0 to N-1 and wraps to 0.
- R2: For an even N, the output is high for N/2 input periods and low for N/2 input periods in every output period.
- R3: For an even N, every output transition happens just after a rising edge of the input clock, and the falling-edge phase signal stays low.
- R4: For an odd N of at least 3, the output is high for N half input periods and low for N half input periods in every output period.
- R5: While rst is sampled high on consecutive rising edges, the output is low. After rst is released the output starts its divided waveform with no further input.
- R6: A ratio of 0 or 1 holds both counters cleared and keeps the output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Clock to be divided, assumed 50% duty |
| rst | input | 1 | Synchronous active-high reset, sampled on both input clock edges |
| ratio | input | W | Division ratio N; 0 and 1 park the output low |
| clk_out | output | 1 | Divided clock with 50% duty |

## Verification
The bench resets the divider for every ratio from 2 to 9 and records the output in the middle of each half input period. From that record it measures the period, the high time and the low time in half-period units. A design that rounds the odd high time down would show N-1 half periods high. A design with a falling-edge path that stays live in even mode would show transitions after falling edges. A design with an off-by-one wrap would show a period of 2N±2. The bench also asserts reset during a run and drives ratios 0 and 1. A design that lets its counters run on an invalid ratio, or that clears only one phase flop in reset, leaves the output toggling.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  // Operating mode decoded from the division ratio.
  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,   // ratio below 2: output parked low
    MODE_EVEN = 2'd1,   // rising-edge counter only
    MODE_ODD  = 2'd2    // rising and falling counters combined
  } div_mode_e;

endpackage

// File: rtl/clkdiv_ratio_dec.sv
module clkdiv_ratio_dec
  import clkdiv_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] ratio,
  output div_mode_e    mode,
  output logic [W-1:0] last_cnt,
  output logic [W-1:0] half_cnt
);

  localparam logic [W-1:0] MIN_RATIO = W'(2);

  always_comb begin
    if (ratio < MIN_RATIO) begin
      mode = MODE_IDLE;
    end else if (ratio[0]) begin
      mode = MODE_ODD;
    end else begin
      mode = MODE_EVEN;
    end
    // Counter wraps after reaching N-1.
    last_cnt = ratio - 1'b1;
    // High phase covers counts below floor(N/2), for both parities.
    half_cnt = ratio >> 1;
  end

endmodule

// File: rtl/clkdiv_phase_cnt.sv
module clkdiv_phase_cnt #(
  parameter int W         = 8,
  parameter bit FALL_EDGE = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic [W-1:0] last_cnt,
  input  logic [W-1:0] half_cnt,
  output logic [W-1:0] cnt_o,
  output logic         phase_o
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_nxt;
  logic         phase_q;
  logic         phase_nxt;

  always_comb begin
    // Compare with >= so a shrunken ratio cannot strand the count.
    cnt_nxt   = (cnt_q >= last_cnt) ? '0 : cnt_q + 1'b1;
    phase_nxt = (cnt_nxt < half_cnt);
  end

  generate
    if (FALL_EDGE) begin : g_fall
      always_ff @(negedge clk) begin
        if (rst || !run) begin
          cnt_q   <= '0;
          phase_q <= 1'b0;
        end else begin
          cnt_q   <= cnt_nxt;
          phase_q <= phase_nxt;
        end
      end
    end else begin : g_rise
      always_ff @(posedge clk) begin
        if (rst || !run) begin
          cnt_q   <= '0;
          phase_q <= 1'b0;
        end else begin
          cnt_q   <= cnt_nxt;
          phase_q <= phase_nxt;
        end
      end
    end
  endgenerate

  assign cnt_o   = cnt_q;
  assign phase_o = phase_q;

endmodule

// File: rtl/clkdiv_combine.sv
module clkdiv_combine
  import clkdiv_pkg::*;
(
  input  div_mode_e mode,
  input  logic      ph_rise,
  input  logic      ph_fall,
  output logic      clk_out
);

  always_comb begin
    unique case (mode)
      MODE_EVEN: clk_out = ph_rise;
      MODE_ODD:  clk_out = ph_rise | ph_fall;
      default:   clk_out = 1'b0;
    endcase
  end

endmodule

// File: rtl/clkdiv_half_duty.sv
module clkdiv_half_duty
  import clkdiv_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_in,
  input  logic         rst,
  input  logic [W-1:0] ratio,
  output logic         clk_out
);

  div_mode_e    mode;
  logic [W-1:0] last_cnt;
  logic [W-1:0] half_cnt;
  logic [W-1:0] cnt_rise;
  logic [W-1:0] cnt_fall;
  logic         ph_rise;
  logic         ph_fall;
  logic         run_rise;
  logic         run_fall;

  assign run_rise = (mode != MODE_IDLE);
  assign run_fall = (mode == MODE_ODD);

  clkdiv_ratio_dec #(.W(W)) u_dec (
    .ratio    (ratio),
    .mode     (mode),
    .last_cnt (last_cnt),
    .half_cnt (half_cnt)
  );

  clkdiv_phase_cnt #(.W(W), .FALL_EDGE(1'b0)) u_rise (
    .clk      (clk_in),
    .rst      (rst),
    .run      (run_rise),
    .last_cnt (last_cnt),
    .half_cnt (half_cnt),
    .cnt_o    (cnt_rise),
    .phase_o  (ph_rise)
  );

  clkdiv_phase_cnt #(.W(W), .FALL_EDGE(1'b1)) u_fall (
    .clk      (clk_in),
    .rst      (rst),
    .run      (run_fall),
    .last_cnt (last_cnt),
    .half_cnt (half_cnt),
    .cnt_o    (cnt_fall),
    .phase_o  (ph_fall)
  );

  clkdiv_combine u_comb (
    .mode    (mode),
    .ph_rise (ph_rise),
    .ph_fall (ph_fall),
    .clk_out (clk_out)
  );

endmodule

// File: rtl/clkdiv_half_duty_chk.sv
module clkdiv_half_duty_chk #(
  parameter int W = 8
) (
  input logic         clk_in,
  input logic         rst,
  input logic [W-1:0] ratio,
  input logic         clk_out,
  input logic         ph_rise,
  input logic         ph_fall,
  input logic [W-1:0] cnt_rise,
  input logic [W-1:0] cnt_fall
);

  localparam logic [W-1:0] MIN_RATIO = W'(2);

  logic rst_q = 1'b0;
  always_ff @(posedge clk_in) rst_q <= rst;

  // R5: reset held across two rising edges leaves the output low
  assert_reset_low_R5: assert property (@(posedge clk_in)
    (rst && rst_q) |-> !clk_out)
    else $error("reset did not hold output low");

  // R1: rising counter stays within 0..N-1 once the ratio is steady
  assert_rise_cnt_range_R1: assert property (@(posedge clk_in) disable iff (rst)
    ((ratio >= MIN_RATIO) && $stable(ratio)) |-> (cnt_rise <= ratio - 1'b1))
    else $error("rising counter out of range");

  // R1: falling counter stays within 0..N-1 once the ratio is steady
  assert_fall_cnt_range_R1: assert property (@(posedge clk_in) disable iff (rst)
    ((ratio >= MIN_RATIO) && $stable(ratio)) |-> (cnt_fall <= ratio - 1'b1))
    else $error("falling counter out of range");

  // R3: even ratio keeps the falling-edge phase idle
  assert_even_fall_idle_R3: assert property (@(posedge clk_in) disable iff (rst)
    (!ratio[0] && $stable(ratio)) |-> !ph_fall)
    else $error("falling path active for even ratio");

  // R6: invalid ratio keeps the output and both phases low
  assert_low_ratio_idle_R6: assert property (@(posedge clk_in) disable iff (rst)
    ((ratio < MIN_RATIO) && $stable(ratio)) |-> (!clk_out && !ph_rise && !ph_fall))
    else $error("output active for ratio below 2");

endmodule

bind clkdiv_half_duty clkdiv_half_duty_chk #(.W(W)) u_chk (
  .clk_in   (clk_in),
  .rst      (rst),
  .ratio    (ratio),
  .clk_out  (clk_out),
  .ph_rise  (ph_rise),
  .ph_fall  (ph_fall),
  .cnt_rise (cnt_rise),
  .cnt_fall (cnt_fall)
);

// File: tb/sim_clkdiv_half_duty.sv
`timescale 1ns/1ps
module sim_clkdiv_half_duty;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] ratio = W'(2);
  logic         clk_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic smp [0:255];

  always #4 clk = ~clk;   // 125 MHz

  clkdiv_half_duty #(.W(W)) u0 (
    .clk_in  (clk),
    .rst     (rst),
    .ratio   (ratio),
    .clk_out (clk_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One sample 2 ns after each input edge; even index follows a rising edge.
  task automatic capture(input int nsmp);
    for (int k = 0; k < nsmp; k++) begin
      if (k % 2 == 0) @(posedge clk); else @(negedge clk);
      #2;
      smp[k] = clk_out;
    end
  endtask

  task automatic restart(input int n);
    @(posedge clk); #2;
    rst   = 1'b1;
    ratio = W'(n);
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
  endtask

  task automatic measure(input int n);
    int nsmp, r0, f0, r1, bad_edges;
    nsmp = 12 * n;
    r0 = -1; f0 = -1; r1 = -1; bad_edges = 0;
    restart(n);
    repeat (2 * n + 2) @(posedge clk);
    capture(nsmp);
    for (int k = 1; k < nsmp; k++) begin
      if (smp[k-1] !== smp[k] && (k % 2 == 1)) bad_edges++;
      if (!smp[k-1] && smp[k]) begin
        if (r0 < 0) r0 = k;
        else if (f0 >= 0 && r1 < 0) r1 = k;
      end
      if (smp[k-1] && !smp[k] && r0 >= 0 && f0 < 0) f0 = k;
    end
    // R1: period in half input periods
    check(r0 >= 0 && f0 > r0 && r1 > f0, "R1 edges found", r1, 1);
    check((r1 - r0) == 2 * n, "R1 period", r1 - r0, 2 * n);
    if (n % 2 == 0) begin
      check((f0 - r0) == n, "R2 high time even", f0 - r0, n);
      check((r1 - f0) == n, "R2 low time even", r1 - f0, n);
      check(bad_edges == 0, "R3 edges after falling clock", bad_edges, 0);
    end else begin
      check((f0 - r0) == n, "R4 high time odd", f0 - r0, n);
      check((r1 - f0) == n, "R4 low time odd", r1 - f0, n);
    end
  endtask

  task automatic all_low(input int nsmp, input string req);
    int highs;
    highs = 0;
    capture(nsmp);
    for (int k = 0; k < nsmp; k++) if (smp[k] !== 1'b0) highs++;
    check(highs == 0, req, highs, 0);
  endtask

  initial begin
    // R5: output low during reset
    repeat (4) @(posedge clk);
    all_low(8, "R5 low in reset");

    for (int n = 2; n <= 9; n++) measure(n);

    // R5: reset asserted while running ratio 5
    restart(5);
    repeat (17) @(posedge clk);
    #1 rst = 1'b1;
    repeat (2) @(posedge clk);
    all_low(10, "R5 low after mid-run reset");
    #1 rst = 1'b0;
    repeat (6) @(posedge clk);
    capture(20);
    begin
      int highs;
      highs = 0;
      for (int k = 0; k < 20; k++) if (smp[k]) highs++;
      check(highs == 10, "R5 resumes after release", highs, 10);
    end

    // R6: ratios 0 and 1 park the output
    restart(0);
    all_low(24, "R6 ratio 0 low");
    restart(1);
    all_low(24, "R6 ratio 1 low");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog all requirements actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule